// File: doc/BRIEF.md
# Regulator Reconfiguration Completion Handshake

This block sits between an SPI packet decoder and the voltage-regulator ramp controllers of a power-management device. A host opens a burst by pulling chip-select low. It then writes up to eight address/data packets, each naming a rail, and closes the burst by releasing chip-select. Each accepted packet produces a one-cycle ramp-start strobe for the rail it names, together with its data byte, so a rail can begin ramping before the burst closes. The block records every addressed rail in a pending mask.

When chip-select rises, the block drops an active-high completion flag. The flag stays low for a guaranteed minimum time. It returns high once every pending rail reports regulation, or when a timeout expires, in which case a timeout flag is set. A rising edge on the exit-standby input starts the same sequence for every rail marked as standby-controlled. A burst that opens while a completion is still pending adds its rails to the pending ones.

The packet input is a valid/ready stream. `pkt_ready` rises on the first clock after reset and then stays high, so the source is never stalled. A transfer happens on any cycle where valid and ready are both high. Transfers that arrive outside a burst, or past the per-burst limit, complete on the interface but are discarded.

Top module: `vreg_done_hs`

## Requirements
- R1: After reset, `vr_done` is 1, `ramp_start` is 0, `ovf_err` and `tmo_flag` are 0, and no rail is pending. `pkt_ready` is 1 from the first clock edge after reset and never falls.
- R2: A transfer accepted while chip-select is low, with address below N_RAILS, raises bit `pkt_addr` of `ramp_start` for exactly the next cycle, and `ramp_data` then equals the packet data. A transfer with address ≥ N_RAILS, or one made while chip-select is high, produces no strobe and adds no pending rail.
- R3: `vr_done` stays high while a burst is collecting. It is low on the cycle after the clock edge that sees chip-select rise.
- R4: `vr_done` returns high only when every rail pending for the sequence has its bit set in `rail_in_reg` (bit i is rail i).
- R5: After `vr_done` falls with every pending rail already in regulation, it stays low for exactly MIN_CYC+1 cycles. MIN_CYC is CLK_KHZ·MIN_LOW_NS/10⁶, rounded up, so the low time is never below the minimum.
- R6: If the pending rails are not all in regulation after `vr_done` has been low for TMO_CYC = CLK_KHZ·TIMEOUT_US/1000 cycles, `vr_done` returns high anyway and `tmo_flag` is set. `tmo_flag` clears the next time `vr_done` falls.
- R7: Only the first MAX_PKTS transfers of a burst count. Later transfers produce no strobe and are not tracked, and they set `ovf_err`. `ovf_err` clears when chip-select next falls.
- R8: A rising edge of `stby_exit` strobes `ramp_start` with `stby_mask` on the next cycle, adds those rails to the pending set and lowers `vr_done`. Completion then follows R4 to R6.
- R9: A burst that opens while `vr_done` is low keeps the earlier rails pending, adds its own rails, and restarts the minimum-low time when chip-select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Packet transfer request |
| pkt_ready | output | 1 | Packet acceptance, high after reset |
| pkt_addr | input | ADDR_W | Rail index carried by the packet |
| pkt_data | input | DATA_W | Configuration byte carried by the packet |
| spi_cs_n | input | 1 | Active-low chip-select that frames a burst |
| rail_in_reg | input | N_RAILS | Per-rail in-regulation status |
| stby_exit | input | 1 | Exit-standby request, acted on at its rising edge |
| stby_mask | input | N_RAILS | Rails controlled by the standby exit |
| ramp_start | output | N_RAILS | One-cycle per-rail ramp-start strobes |
| ramp_data | output | DATA_W | Data byte of the most recently accepted packet |
| vr_done | output | 1 | Active-high completion flag |
| ovf_err | output | 1 | Burst carried more than MAX_PKTS packets |
| tmo_flag | output | 1 | Last sequence ended by timeout |

## Verification
Three situations are hard to reach from the ports. The first is a rail that was strobed in an earlier burst, is still pending, and must keep `vr_done` low after a second burst has moved regulation onto another rail. The bench builds this by opening a burst during the wait and then swapping which rail reports regulation. The second is the ninth packet, which must leave no trace. The bench holds that rail out of regulation, so any tracking of it would stretch the low time past MIN_CYC+1. The third is the timeout, which the bench reaches by shrinking TIMEOUT_US and holding one addressed rail out of regulation.

// File: rtl/vrh_pkg.sv
package vrh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_COLLECT  = 2'd1,
    ST_WAIT_MIN = 2'd2,
    ST_WAIT_REG = 2'd3
  } vrh_state_e;
endpackage

// File: rtl/vrh_pkt_decode.sv
module vrh_pkt_decode #(
  parameter int N_RAILS  = 8,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 8,
  parameter int MAX_PKTS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               burst_start,
  input  logic               accept_en,
  input  logic               pkt_fire,
  input  logic [ADDR_W-1:0]  pkt_addr,
  input  logic [DATA_W-1:0]  pkt_data,
  input  logic               stby_hit,
  input  logic [N_RAILS-1:0] stby_mask,
  output logic [N_RAILS-1:0] rail_hit,
  output logic [N_RAILS-1:0] ramp_start,
  output logic [DATA_W-1:0]  ramp_data,
  output logic               ovf_err
);
  localparam int CNT_W = $clog2(MAX_PKTS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             room;
  logic             take;
  logic             spill;

  assign room  = cnt_q < CNT_W'(MAX_PKTS);
  assign take  = accept_en && pkt_fire && room;
  assign spill = accept_en && pkt_fire && !room;

  // one comparator per rail; indices at or above N_RAILS match nothing
  for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
    assign rail_hit[g] = take && (pkt_addr == ADDR_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      ovf_err    <= 1'b0;
      ramp_start <= '0;
      ramp_data  <= '0;
    end else begin
      ramp_start <= rail_hit | (stby_hit ? stby_mask : '0);
      if (take) ramp_data <= pkt_data;
      if (burst_start) begin
        cnt_q   <= '0;
        ovf_err <= 1'b0;
      end else begin
        if (take)  cnt_q   <= cnt_q + 1'b1;
        if (spill) ovf_err <= 1'b1;
      end
    end
  end

  // R2
  ramp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ramp_start) |-> $past(take || stby_hit));

  // R7
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> (cnt_q == CNT_W'(MAX_PKTS)));
endmodule

// File: rtl/vrh_lowtime.sv
module vrh_lowtime #(
  parameter int MIN_CYC = 25,
  parameter int TMO_CYC = 1500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_min,
  input  logic run_min,
  input  logic restart_tmo,
  input  logic run_tmo,
  output logic min_done,
  output logic tmo_hit
);
  localparam int MIN_W = $clog2(MIN_CYC + 1);
  localparam int TMO_W = $clog2(TMO_CYC + 1);

  logic [MIN_W-1:0] min_q;
  logic [TMO_W-1:0] tmo_q;

  assign min_done = (min_q == MIN_W'(MIN_CYC - 1));
  assign tmo_hit  = (tmo_q == TMO_W'(TMO_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q <= '0;
      tmo_q <= '0;
    end else begin
      if (restart_min)              min_q <= '0;
      else if (run_min && !min_done) min_q <= min_q + 1'b1;
      if (restart_tmo)              tmo_q <= '0;
      else if (run_tmo && !tmo_hit)  tmo_q <= tmo_q + 1'b1;
    end
  end

  // R5
  min_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_min && MIN_CYC > 1) |=> !min_done);
endmodule

// File: rtl/vreg_done_hs.sv
module vreg_done_hs #(
  parameter int N_RAILS    = 8,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int MAX_PKTS   = 8,
  parameter int CLK_KHZ    = 50000,
  parameter int MIN_LOW_NS = 500,
  parameter int TIMEOUT_US = 30000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pkt_valid,
  output logic               pkt_ready,
  input  logic [ADDR_W-1:0]  pkt_addr,
  input  logic [DATA_W-1:0]  pkt_data,
  input  logic               spi_cs_n,
  input  logic [N_RAILS-1:0] rail_in_reg,
  input  logic               stby_exit,
  input  logic [N_RAILS-1:0] stby_mask,
  output logic [N_RAILS-1:0] ramp_start,
  output logic [DATA_W-1:0]  ramp_data,
  output logic               vr_done,
  output logic               ovf_err,
  output logic               tmo_flag
);
  import vrh_pkg::*;

  localparam longint MIN_RAW = (longint'(CLK_KHZ) * MIN_LOW_NS + 64'd999_999) / 64'd1_000_000;
  localparam int     MIN_CYC = (MIN_RAW < 1) ? 1 : int'(MIN_RAW);
  localparam longint TMO_RAW = (longint'(CLK_KHZ) * TIMEOUT_US) / 64'd1000;
  localparam int     TMO_CYC = (TMO_RAW <= MIN_CYC) ? MIN_CYC + 2 : int'(TMO_RAW);

  initial begin
    if (N_RAILS < 8 || N_RAILS > 16 || (1 << ADDR_W) < N_RAILS)
      $error("vreg_done_hs: rail count or address width out of range");
  end

  vrh_state_e st_q, st_d;
  logic [N_RAILS-1:0] pend_q, pend_d, rail_hit;
  logic cs_q, stby_q, done_d, tmo_d;
  logic cs_fall, cs_rise, stby_rise, lower;
  logic restart_min, restart_tmo, min_done, tmo_hit, all_ok;
  logic accept_en, pkt_fire;

  assign cs_fall   = cs_q && !spi_cs_n;
  assign cs_rise   = !cs_q && spi_cs_n;
  assign stby_rise = stby_exit && !stby_q;
  assign accept_en = (st_q == ST_COLLECT) && !spi_cs_n;
  assign pkt_fire  = pkt_valid && pkt_ready;
  assign all_ok    = ((pend_q & ~rail_in_reg) == '0);
  assign lower     = !cs_fall && (((st_q == ST_COLLECT) && cs_rise) ||
                                  ((st_q != ST_COLLECT) && stby_rise));

  vrh_pkt_decode #(
    .N_RAILS(N_RAILS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_PKTS(MAX_PKTS)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .burst_start(cs_fall), .accept_en(accept_en),
    .pkt_fire(pkt_fire), .pkt_addr(pkt_addr), .pkt_data(pkt_data),
    .stby_hit(stby_rise), .stby_mask(stby_mask), .rail_hit(rail_hit),
    .ramp_start(ramp_start), .ramp_data(ramp_data), .ovf_err(ovf_err)
  );

  vrh_lowtime #(.MIN_CYC(MIN_CYC), .TMO_CYC(TMO_CYC)) u_lowtime (
    .clk(clk), .rst_n(rst_n), .restart_min(restart_min),
    .run_min(st_q == ST_WAIT_MIN), .restart_tmo(restart_tmo),
    .run_tmo(!vr_done), .min_done(min_done), .tmo_hit(tmo_hit)
  );

  always_comb begin
    st_d        = st_q;
    done_d      = vr_done;
    tmo_d       = tmo_flag;
    pend_d      = pend_q | rail_hit | (stby_rise ? stby_mask : '0);
    restart_min = 1'b0;
    restart_tmo = 1'b0;
    if (cs_fall) begin
      st_d = ST_COLLECT;
    end else if (lower) begin
      st_d        = ST_WAIT_MIN;
      done_d      = 1'b0;
      tmo_d       = 1'b0;
      restart_min = 1'b1;
      restart_tmo = vr_done;
    end else begin
      case (st_q)
        ST_WAIT_MIN: if (min_done) st_d = ST_WAIT_REG;
        ST_WAIT_REG: begin
          if (all_ok || tmo_hit) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            pend_d = '0;
            tmo_d  = !all_ok;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      pend_q    <= '0;
      cs_q      <= 1'b1;
      stby_q    <= 1'b0;
      vr_done   <= 1'b1;
      tmo_flag  <= 1'b0;
      pkt_ready <= 1'b0;
    end else begin
      st_q      <= st_d;
      pend_q    <= pend_d;
      cs_q      <= spi_cs_n;
      stby_q    <= stby_exit;
      vr_done   <= done_d;
      tmo_flag  <= tmo_d;
      pkt_ready <= 1'b1;
    end
  end

  // R3
  done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vr_done) |-> $past(cs_rise || stby_rise));

  // R5
  done_rise_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vr_done) |-> $past(st_q == ST_WAIT_REG));

  // R4
  done_rise_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vr_done) && !tmo_flag) |-> $past((pend_q & ~rail_in_reg) == '0));

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pkt_ready) |-> pkt_ready);
endmodule

// File: tb/vreg_done_hs_tb.sv
module vreg_done_hs_tb;
  localparam int N   = 8;
  localparam int MIN = 500 / 20;      // 500 ns at 20 ns period
  localparam int TMO = 20000 / 20;    // 20 us at 20 ns period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_valid = 1'b0;
  logic pkt_ready;
  logic [4:0] pkt_addr = '0;
  logic [7:0] pkt_data = '0;
  logic spi_cs_n = 1'b1;
  logic [N-1:0] rail_in_reg = '1;
  logic stby_exit = 1'b0;
  logic [N-1:0] stby_mask = '0;
  logic [N-1:0] ramp_start;
  logic [7:0] ramp_data;
  logic vr_done, ovf_err, tmo_flag;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  vreg_done_hs #(
    .N_RAILS(8), .ADDR_W(5), .DATA_W(8), .MAX_PKTS(8),
    .CLK_KHZ(50000), .MIN_LOW_NS(500), .TIMEOUT_US(20)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_addr(pkt_addr), .pkt_data(pkt_data), .spi_cs_n(spi_cs_n),
    .rail_in_reg(rail_in_reg), .stby_exit(stby_exit), .stby_mask(stby_mask),
    .ramp_start(ramp_start), .ramp_data(ramp_data), .vr_done(vr_done),
    .ovf_err(ovf_err), .tmo_flag(tmo_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic cs_open();
    @(negedge clk) spi_cs_n = 1'b0;
  endtask

  task automatic cs_close();
    @(negedge clk) spi_cs_n = 1'b1;
  endtask

  task automatic send(input int addr, input int data, input int exp_ramp, input string req);
    @(negedge clk);
    pkt_valid = 1'b1;
    pkt_addr  = 5'(addr);
    pkt_data  = 8'(data);
    @(negedge clk);
    pkt_valid = 1'b0;
    chk(ramp_start == N'(exp_ramp), req, int'(ramp_start), exp_ramp);
    if (exp_ramp != 0) chk(ramp_data == 8'(data), req, int'(ramp_data), data);
    @(negedge clk);
    chk(ramp_start == '0, req, int'(ramp_start), 0);
  endtask

  task automatic measure_low(output int n);
    n = 0;
    while (n < 5000) begin
      @(negedge clk);
      if (vr_done) break;
      n++;
    end
  endtask

  initial begin
    int lo;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(vr_done == 1'b1, "R1 done", int'(vr_done), 1);
    chk(ramp_start == '0, "R1 ramp", int'(ramp_start), 0);
    chk(ovf_err == 1'b0 && tmo_flag == 1'b0, "R1 flags", int'({ovf_err, tmo_flag}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pkt_ready == 1'b1, "R1 ready", int'(pkt_ready), 1);

    // R2 outside a burst: no strobe, done stays high
    send(2, 8'h11, 0, "R2 cs high");
    chk(vr_done == 1'b1, "R2 done idle", int'(vr_done), 1);

    // R4 / R2 / R3 sweep over rail subsets
    for (int m = 0; m < 256; m += 15) begin
      int hi;
      hi = -1;
      rail_in_reg = ~N'(m);
      cs_open();
      for (int r = 0; r < N; r++) begin
        if (m[r]) begin
          send(r, (m ^ r) & 8'hFF, 1 << r, "R2 strobe");
          hi = r;
        end
      end
      chk(vr_done == 1'b1, "R3 high while collecting", int'(vr_done), 1);
      cs_close();
      if (m == 0) begin
        measure_low(lo);
        chk(lo == MIN + 1, "R5 empty burst low time", lo, MIN + 1);
      end else begin
        @(negedge clk);
        chk(vr_done == 1'b0, "R3 low after cs rise", int'(vr_done), 0);
        repeat (MIN + 6) @(negedge clk);
        rail_in_reg = '1;
        rail_in_reg[hi] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(vr_done == 1'b0, "R4 one rail outstanding", int'(vr_done), 0);
        rail_in_reg = '1;
        @(negedge clk);
        chk(vr_done == 1'b1, "R4 all regulated", int'(vr_done), 1);
      end
    end

    // R2 out-of-range rail: no strobe, not tracked
    rail_in_reg = '1;
    cs_open();
    send(9, 8'h5A, 0, "R2 out of range");
    send(3, 8'h3C, 8, "R2 in range");
    cs_close();
    measure_low(lo);
    chk(lo == MIN + 1, "R5 low time", lo, MIN + 1);

    // R7 overflow: ninth packet is ignored
    rail_in_reg = 8'h7F;
    cs_open();
    for (int r = 0; r < 7; r++) send(r, r + 1, 1 << r, "R7 within limit");
    send(0, 8'h44, 1, "R7 eighth");
    chk(ovf_err == 1'b0, "R7 no ovf at limit", int'(ovf_err), 0);
    send(7, 8'h99, 0, "R7 ninth ignored");
    chk(ovf_err == 1'b1, "R7 ovf set", int'(ovf_err), 1);
    cs_close();
    measure_low(lo);
    chk(lo == MIN + 1, "R7 ninth rail not tracked", lo, MIN + 1);
    chk(ovf_err == 1'b1, "R7 ovf sticky", int'(ovf_err), 1);
    rail_in_reg = '1;
    cs_open();
    @(negedge clk);
    chk(ovf_err == 1'b0, "R7 ovf cleared", int'(ovf_err), 0);
    cs_close();
    measure_low(lo);

    // R6 timeout
    rail_in_reg = 8'hFB;
    cs_open();
    send(2, 8'h21, 4, "R6 strobe");
    cs_close();
    measure_low(lo);
    chk(lo == TMO, "R6 timeout low time", lo, TMO);
    chk(tmo_flag == 1'b1, "R6 tmo set", int'(tmo_flag), 1);
    rail_in_reg = '1;
    cs_open();
    cs_close();
    @(negedge clk);
    chk(tmo_flag == 1'b0, "R6 tmo cleared", int'(tmo_flag), 0);
    measure_low(lo);

    // R8 standby exit
    stby_mask = 8'hA0;
    rail_in_reg = 8'h5F;
    @(negedge clk) stby_exit = 1'b1;
    @(negedge clk);
    chk(ramp_start == 8'hA0, "R8 strobe mask", int'(ramp_start), 160);
    chk(vr_done == 1'b0, "R8 done low", int'(vr_done), 0);
    stby_exit = 1'b0;
    repeat (MIN + 5) @(negedge clk);
    chk(vr_done == 1'b0, "R8 waits for rails", int'(vr_done), 0);
    rail_in_reg = '1;
    @(negedge clk);
    chk(vr_done == 1'b1, "R8 completes", int'(vr_done), 1);

    // R9 merge keeps earlier rails pending
    rail_in_reg = 8'hFD;
    cs_open();
    send(1, 8'h01, 2, "R9 burst A");
    cs_close();
    repeat (MIN + 5) @(negedge clk);
    cs_open();
    send(2, 8'h02, 4, "R9 burst B");
    rail_in_reg = 8'hF9;
    cs_close();
    repeat (MIN + 5) @(negedge clk);
    rail_in_reg = 8'hFB;
    repeat (2) @(negedge clk);
    chk(vr_done == 1'b0, "R9 new rail pending", int'(vr_done), 0);
    rail_in_reg = 8'hFD;
    repeat (2) @(negedge clk);
    chk(vr_done == 1'b0, "R9 old rail still pending", int'(vr_done), 0);
    rail_in_reg = '1;
    @(negedge clk);
    chk(vr_done == 1'b1, "R9 merged complete", int'(vr_done), 1);

    // R9 merge restarts the minimum low time
    rail_in_reg = 8'hFD;
    cs_open();
    send(1, 8'h07, 2, "R9 restart A");
    cs_close();
    repeat (MIN + 5) @(negedge clk);
    cs_open();
    send(4, 8'h08, 16, "R9 restart B");
    rail_in_reg = '1;
    cs_close();
    measure_low(lo);
    chk(lo == MIN + 1, "R9 min restarted", lo, MIN + 1);

    finish_run();
  end
endmodule